// File: doc/BRIEF.md
# Up/Down Period Timer

This block is a general-purpose counter whose count clock is an external pin. The pin is brought into the internal clock domain through a short synchronizer. Each rising edge of the synchronized pin is one count tick. The count is compared against a programmable period value. When a tick lands on the boundary, the counter wraps and raises a sticky interrupt flag. The flag stays set until software clears it with a pulse.

The count direction can come from a control bit written by software. It can also come from a second external pin, which is synchronized in the same way. A third control bit stops counting while the chip-level idle input is high. Software loads the count, the period and the control bits through a simple write port. A write to the count takes effect immediately and wins over a tick that falls in the same cycle.

Top module: `updn_period_timer`

## Requirements
- R1: With the direction up, each rising edge seen on `tmr_pin` adds one to the count while the count differs from the period.
- R2: With the direction up, a tick that arrives while the count equals the period loads 0 into the count and sets `irq_flag`.
- R3: With the direction down, each tick subtracts one from a non-zero count. A tick at count 0 loads the period value into the count and sets `irq_flag`.
- R4: When control bit 1 (direction source) is 1, `dir_pin` sets the direction, with high meaning up. When control bit 1 is 0, control bit 0 sets the direction, with 1 meaning up.
- R5: When control bit 2 (idle stop) is 1 and `idle_i` is high, pin edges are dropped and the count holds. When control bit 2 is 0, counting continues while `idle_i` is high.
- R6: Writes select their target with `wr_sel`: 0 for the count, 1 for the period, 2 for the control bits in `wr_data[2:0]`. A control write leaves the count unchanged.
- R7: `irq_flag` stays set until `irq_clr` is pulsed. If a clear and a wrap or reload fall in the same cycle, the flag stays set.
- R8: A count write in the same cycle as a tick loads the written value, and that tick neither counts nor sets the flag.
- R9: The count changes on the third rising clock edge after `tmr_pin` rises. While the pin stays high, no further tick occurs.
- R10: After reset the count is 0, the flag is 0, the period is all ones and all control bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tmr_pin | input | 1 | External count clock pin |
| dir_pin | input | 1 | External direction pin, high means up |
| idle_i | input | 1 | Chip idle indication |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 count, 1 period, 2 control |
| wr_data | input | CNT_W | Write data |
| irq_clr | input | 1 | Flag clear pulse |
| count_o | output | CNT_W | Current count |
| irq_flag | output | 1 | Sticky period-match flag |

## Verification
Two pairs of events can fall in one cycle. In the first, a software clear meets a wrap that sets the flag. In the second, a count write meets a pin tick. The bench drives the clear or the write in the exact cycle in which the synchronized edge is live, which is two clock edges after the pin rises. It then checks at the ports that the set wins over the clear and that the written value wins over the tick. The same pulse shape without a match shows that the clear alone empties the flag.

// File: rtl/updn_tmr_pkg.sv
package updn_tmr_pkg;

   typedef enum logic [1:0] {
      SEL_COUNT  = 2'd0,
      SEL_PERIOD = 2'd1,
      SEL_CTRL   = 2'd2
   } wr_target_e;

   // packed order gives idle_stop = bit 2, dir_src = bit 1, dir_sw = bit 0
   typedef struct packed {
      logic idle_stop;
      logic dir_src;
      logic dir_sw;
   } tmr_ctrl_t;

endpackage

// File: rtl/tmr_sync.sv
module tmr_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("tmr_sync needs at least two stages");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   input  logic hold,
   output logic tick
);
   logic pin_s;
   logic pin_prev;

   tmr_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (pin),
      .q    (pin_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin_prev <= 1'b0;
      else        pin_prev <= pin_s;
   end

   assign tick = pin_s && !pin_prev && !hold;
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         dir_up,
   input  logic         wr_cnt,
   input  logic         wr_per,
   input  logic [W-1:0] wr_data,
   input  logic         irq_clr,
   output logic [W-1:0] count,
   output logic [W-1:0] period,
   output logic         match_evt,
   output logic         irq_flag
);
   logic [W-1:0] count_nxt;

   always_comb begin
      count_nxt = count;
      match_evt = 1'b0;
      if (wr_cnt) begin
         count_nxt = wr_data;
      end else if (tick) begin
         if (dir_up) begin
            if (count == period) begin
               count_nxt = '0;
               match_evt = 1'b1;
            end else begin
               count_nxt = count + W'(1);
            end
         end else begin
            if (count == '0) begin
               count_nxt = period;
               match_evt = 1'b1;
            end else begin
               count_nxt = count - W'(1);
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count    <= '0;
         period   <= '1;
         irq_flag <= 1'b0;
      end else begin
         count <= count_nxt;
         if (wr_per)         period   <= wr_data;
         if (match_evt)      irq_flag <= 1'b1;
         else if (irq_clr)   irq_flag <= 1'b0;
      end
   end
endmodule

// File: rtl/updn_period_timer.sv
module updn_period_timer
   import updn_tmr_pkg::*;
#(
   parameter int CNT_W        = 16,
   parameter int SYNC_STAGES  = 2,
   parameter bit DIR_PIN_SYNC = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tmr_pin,
   input  logic             dir_pin,
   input  logic             idle_i,
   input  logic             wr_en,
   input  logic [1:0]       wr_sel,
   input  logic [CNT_W-1:0] wr_data,
   input  logic             irq_clr,
   output logic [CNT_W-1:0] count_o,
   output logic             irq_flag
);
   localparam int CTRL_W = $bits(tmr_ctrl_t);

   generate
      if (CNT_W < CTRL_W) begin : g_bad_width
         $error("CNT_W must hold the control field");
      end
   endgenerate

   tmr_ctrl_t        ctrl_q;
   logic [CNT_W-1:0] period_q;
   logic             wr_cnt, wr_per, wr_ctl;
   logic             cnt_tick, dir_pin_s, dir_up, idle_stop, match_evt;

   assign wr_cnt = wr_en && (wr_sel == SEL_COUNT);
   assign wr_per = wr_en && (wr_sel == SEL_PERIOD);
   assign wr_ctl = wr_en && (wr_sel == SEL_CTRL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ctrl_q <= '0;
      else if (wr_ctl) ctrl_q <= tmr_ctrl_t'(wr_data[CTRL_W-1:0]);
   end

   assign idle_stop = ctrl_q.idle_stop;

   tmr_tick_gen #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .pin  (tmr_pin),
      .hold (idle_i && idle_stop),
      .tick (cnt_tick)
   );

   generate
      if (DIR_PIN_SYNC) begin : g_dir_sync
         tmr_sync #(.STAGES(SYNC_STAGES)) u_dir_sync (
            .clk  (clk),
            .rst_n(rst_n),
            .d    (dir_pin),
            .q    (dir_pin_s)
         );
      end else begin : g_dir_raw
         assign dir_pin_s = dir_pin;
      end
   endgenerate

   assign dir_up = ctrl_q.dir_src ? dir_pin_s : ctrl_q.dir_sw;

   tmr_count_core #(.W(CNT_W)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (cnt_tick),
      .dir_up   (dir_up),
      .wr_cnt   (wr_cnt),
      .wr_per   (wr_per),
      .wr_data  (wr_data),
      .irq_clr  (irq_clr),
      .count    (count_o),
      .period   (period_q),
      .match_evt(match_evt),
      .irq_flag (irq_flag)
   );
endmodule

// File: rtl/updn_period_timer_chk.sv
module updn_period_timer_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick,
   input logic             wr_cnt,
   input logic             dir_up,
   input logic [CNT_W-1:0] count,
   input logic [CNT_W-1:0] period,
   input logic [CNT_W-1:0] wr_data,
   input logic             irq_clr,
   input logic             match_evt,
   input logic             irq_flag,
   input logic             idle_i,
   input logic             idle_stop
);
   assert_up_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
      tick && !wr_cnt && dir_up && count != period |=> count == CNT_W'($past(count) + 1));

   assert_up_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tick && !wr_cnt && dir_up && count == period |=> count == '0 && irq_flag);

   assert_down_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      tick && !wr_cnt && !dir_up && count != '0 |=> count == CNT_W'($past(count) - 1));

   assert_down_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
      tick && !wr_cnt && !dir_up && count == '0 |=> count == $past(period) && irq_flag);

   assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      idle_i && idle_stop && !wr_cnt |=> $stable(count));

   assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_flag && !irq_clr |=> irq_flag);

   assert_flag_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      irq_clr && !match_evt |=> !irq_flag);

   assert_write_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_cnt |=> count == $past(wr_data));
endmodule

bind updn_period_timer updn_period_timer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tick     (cnt_tick),
   .wr_cnt   (wr_cnt),
   .dir_up   (dir_up),
   .count    (count_o),
   .period   (period_q),
   .wr_data  (wr_data),
   .irq_clr  (irq_clr),
   .match_evt(match_evt),
   .irq_flag (irq_flag),
   .idle_i   (idle_i),
   .idle_stop(idle_stop)
);

// File: tb/updn_period_timer_tb.sv
module updn_period_timer_tb;
   localparam int W = 4;
   localparam int MAXV = (1 << W) - 1;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         tmr_pin = 1'b0, dir_pin = 1'b0, idle_i = 1'b0;
   logic         wr_en = 1'b0, irq_clr = 1'b0;
   logic [1:0]   wr_sel = 2'd0;
   logic [W-1:0] wr_data = '0;
   logic [W-1:0] count_o;
   logic         irq_flag;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   updn_period_timer #(.CNT_W(W)) u_dut (
      .clk(clk), .rst_n(rst_n), .tmr_pin(tmr_pin), .dir_pin(dir_pin),
      .idle_i(idle_i), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .irq_clr(irq_clr), .count_o(count_o), .irq_flag(irq_flag)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] sel, input int val);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = W'(val);
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   // one pin pulse; clr and count write land in the cycle the edge is live
   task automatic pulse(input logic clr, input logic wcnt, input int wval);
      @(negedge clk) tmr_pin = 1'b1;
      @(negedge clk);
      @(negedge clk);
      irq_clr = clr;
      if (wcnt) begin wr_en = 1'b1; wr_sel = 2'd0; wr_data = W'(wval); end
      @(negedge clk);
      irq_clr = 1'b0; wr_en = 1'b0; tmr_pin = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic clear_flag();
      @(negedge clk) irq_clr = 1'b1;
      @(negedge clk) irq_clr = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 count", count_o, 0);
      chk("R10 flag", irq_flag, 0);
      pulse(1'b0, 1'b0, 0);
      chk("R10 period all ones, up by default off -> down reload", count_o, MAXV);
      clear_flag();

      // R1/R2 up sweep over every period
      for (int p = 0; p <= MAXV; p++) begin
         wr(2'd1, p); wr(2'd2, 3'b001); wr(2'd0, 0); clear_flag();
         for (int n = 1; n <= p + 2; n++) begin
            pulse(1'b0, 1'b0, 0);
            chk("R1 R2 up count", count_o, n % (p + 1));
            chk("R2 up flag", irq_flag, (n >= p + 1) ? 1 : 0);
         end
      end

      // R3 down sweep over every period
      for (int p = 0; p <= MAXV; p++) begin
         wr(2'd1, p); wr(2'd2, 3'b000); wr(2'd0, p); clear_flag();
         for (int n = 1; n <= p + 2; n++) begin
            pulse(1'b0, 1'b0, 0);
            chk("R3 down count", count_o, p - (n % (p + 1)));
            chk("R3 down flag", irq_flag, (n >= p + 1) ? 1 : 0);
         end
      end

      // R4 direction from pin overrides software bit
      wr(2'd1, MAXV); wr(2'd0, 7); wr(2'd2, 3'b011); dir_pin = 1'b0;
      pulse(1'b0, 1'b0, 0);
      chk("R4 pin low counts down", count_o, 6);
      dir_pin = 1'b1;
      pulse(1'b0, 1'b0, 0);
      chk("R4 pin high counts up", count_o, 7);
      wr(2'd2, 3'b000);
      pulse(1'b0, 1'b0, 0);
      chk("R4 software bit down ignores pin", count_o, 6);

      // R6 control writes keep the count
      wr(2'd2, 3'b111);
      chk("R6 count kept", count_o, 6);
      wr(2'd2, 3'b001);
      chk("R6 count kept again", count_o, 6);

      // R5 idle stop
      idle_i = 1'b1; wr(2'd2, 3'b101);
      repeat (3) pulse(1'b0, 1'b0, 0);
      chk("R5 idle stop holds", count_o, 6);
      wr(2'd2, 3'b001);
      repeat (3) pulse(1'b0, 1'b0, 0);
      chk("R5 idle without stop counts", count_o, 9);
      idle_i = 1'b0;

      // R9 latency and held pin
      wr(2'd0, 2);
      @(negedge clk) tmr_pin = 1'b1;
      @(negedge clk) chk("R9 no change after 1 edge", count_o, 2);
      @(negedge clk) chk("R9 no change after 2 edges", count_o, 2);
      @(negedge clk) chk("R9 change after 3 edges", count_o, 3);
      repeat (5) @(negedge clk);
      chk("R9 held pin no retick", count_o, 3);
      tmr_pin = 1'b0;
      repeat (3) @(negedge clk);

      // R8 write beats tick, no flag from that tick
      wr(2'd1, 5); wr(2'd0, 5); clear_flag();
      pulse(1'b0, 1'b1, 9);
      chk("R8 written value wins", count_o, 9);
      chk("R8 no flag from dropped tick", irq_flag, 0);

      // R7 clear collides with wrap: set wins
      wr(2'd0, 5);
      pulse(1'b0, 1'b0, 0);
      chk("R7 flag set on wrap", irq_flag, 1);
      wr(2'd0, 5);
      pulse(1'b1, 1'b0, 0);
      chk("R7 set beats clear", irq_flag, 1);
      chk("R7 count wrapped", count_o, 0);
      repeat (4) @(negedge clk);
      chk("R7 flag sticky", irq_flag, 1);
      pulse(1'b1, 1'b0, 0);
      chk("R7 clear alone", irq_flag, 0);
      chk("R1 count after clear tick", count_o, 1);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule